// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether an I/O access issued by the running task may go ahead. A request carries the port address, the access width (one, two or four bytes), the current privilege level and the I/O privilege level. The task segment's bitmap offset and segment limit come with it. When the current level is privileged enough, the block grants the access at once. Otherwise it reads the permission bitmap stored inside the task segment and answers with allow or fault.

The bitmap holds one bit per port byte address. The bit for port P is at bit P mod 8 of the byte at segment offset base + P/8. The block always reads a little-endian 16-bit word at that offset, so a window of up to four bits that spills into the next byte is still covered. A byte that lies past the segment limit is never read. Its bits count as ones, which denies every port it would cover.

Requests use a valid/ready handshake, and only one check is in flight at a time. The result comes back as a single-cycle `done` pulse with `allow` or `fault`. Bitmap words come from a read port with a request/valid handshake, and that port may take any number of cycles to answer.

Top module: `iopm_checker`

## Requirements
- R1: When the current level is numerically less than or equal to the I/O level, the result is allow in the cycle after acceptance, and no bitmap read is issued.
- R2: When the bypass does not apply, the read address is base + (port >> 3), and the bit tested first is bit (port mod 8) of the byte at that address. Example: port 41 with base B reads at B+5 and tests bit 1.
- R3: The size code selects the bits tested from the starting bit upward: 2'b00 tests 1 bit, 2'b01 tests 2 bits, and 2'b10 or 2'b11 tests 4 bits.
- R4: The read returns a 16-bit word: data[7:0] is the byte at the read address and data[15:8] is the next byte. A window that runs past bit 7 tests the low bits of the next byte.
- R5: The result is fault if any tested bit is 1, and allow only when every tested bit is 0.
- R6: If base + (port >> 3), computed with 17 bits, is greater than the limit, the result is fault and no read is issued. A sum that carries past 16 bits also counts as greater.
- R7: If the read address equals the limit, the upper byte of the returned word is treated as 8'hFF. A window that reaches that byte faults, and one that does not reach it is decided by the lower byte alone.
- R8: `req_ready` is high only when no check is in flight. `done` is high for exactly one cycle per accepted request, and during that cycle exactly one of `allow` and `fault` is high. Both are low whenever `done` is low.
- R9: Once raised, `mem_rd_req` stays high with an unchanged `mem_rd_addr` until `mem_rd_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | 16 | Port address of the access |
| req_size | input | 2 | Access width code (00=1, 01=2, 1x=4 bytes) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| tss_map_base | input | 16 | Bitmap offset inside the task segment |
| tss_limit | input | 16 | Last valid byte offset of the task segment |
| mem_rd_req | output | 1 | Bitmap word read request |
| mem_rd_addr | output | 16 | Segment offset of the lower byte of the word |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 16 | Returned word, lower byte at the address |
| done | output | 1 | Result pulse |
| allow | output | 1 | Access may proceed (valid with done) |
| fault | output | 1 | General-protection fault (valid with done) |

## Verification
Corrupted latched request fields show up first at `mem_rd_addr`, one cycle after acceptance. They can also appear as a read issued or skipped against the privilege bypass. A wrong word register or shift shows up only in the `done` cycle, as allow flipped to fault or the reverse. This makes ports whose window starts at bits 5 to 7 and words that touch the limit the telling cases. A state machine stuck outside idle keeps `req_ready` low, and the next request hangs in plain view.

// File: rtl/iopm_pkg.sv
package iopm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_CHECK_PRIV = 2'd1,
    ST_READ       = 2'd2,
    ST_EVAL       = 2'd3
  } iopm_state_e;

  // Width code to bit mask: 00 -> one bit, 01 -> two bits, 1x -> four bits.
  function automatic logic [3:0] size_mask(input logic [1:0] sz);
    logic [3:0] m;
    unique case (sz)
      2'b00:   m = 4'b0001;
      2'b01:   m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/iopm_priv.sv
module iopm_priv #(
  parameter int PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  output logic              bypass
);
  // Lower number means more privileged.
  always_comb bypass = (cpl <= iopl);
endmodule

// File: rtl/iopm_addr.sv
module iopm_addr #(
  parameter int PORT_W = 16,
  parameter int OFF_W  = 16
) (
  input  logic [PORT_W-1:0] port,
  input  logic [OFF_W-1:0]  base,
  input  logic [OFF_W-1:0]  limit,
  output logic [OFF_W:0]    off_lo,
  output logic              lo_in,
  output logic              hi_in
);
  localparam int EXT_W = OFF_W + 1;

  logic [EXT_W-1:0] off_hi;
  logic [EXT_W-1:0] lim_ext;

  always_comb begin
    lim_ext = {1'b0, limit};
    off_lo  = {1'b0, base} + EXT_W'(port >> 3);
    off_hi  = off_lo + EXT_W'(1);
    lo_in   = (off_lo <= lim_ext);
    hi_in   = (off_hi <= lim_ext);
  end
endmodule

// File: rtl/iopm_eval.sv
module iopm_eval #(
  parameter int WORD_W = 16,
  parameter int WIN_W  = 4
) (
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        bit_sel,
  input  logic [1:0]        size,
  output logic              hit
);
  import iopm_pkg::*;

  logic [WORD_W-1:0] shifted;
  logic [WIN_W-1:0]  window;

  always_comb begin
    shifted = word >> bit_sel;
    window  = shifted[WIN_W-1:0] & WIN_W'(size_mask(size));
    hit     = |window;
  end
endmodule

// File: rtl/iopm_checker.sv
module iopm_checker #(
  parameter int PORT_W = 16,
  parameter int OFF_W  = 16,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [PRIV_W-1:0] req_cpl,
  input  logic [PRIV_W-1:0] req_iopl,
  input  logic [OFF_W-1:0]  tss_map_base,
  input  logic [OFF_W-1:0]  tss_limit,
  output logic              mem_rd_req,
  output logic [OFF_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [15:0]       mem_rd_data,
  output logic              done,
  output logic              allow,
  output logic              fault
);
  import iopm_pkg::*;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int WIN_W  = 4;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  iopm_state_e       state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        size_q;
  logic [PRIV_W-1:0] cpl_q, iopl_q;
  logic [OFF_W-1:0]  base_q, limit_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;
  logic              accept;

  logic              bypass;
  logic [OFF_W:0]    off_lo;
  logic              lo_in, hi_in;
  logic              hit;

  iopm_priv #(.PRIV_W(PRIV_W)) u_priv (
    .cpl    (cpl_q),
    .iopl   (iopl_q),
    .bypass (bypass)
  );

  iopm_addr #(.PORT_W(PORT_W), .OFF_W(OFF_W)) u_addr (
    .port   (port_q),
    .base   (base_q),
    .limit  (limit_q),
    .off_lo (off_lo),
    .lo_in  (lo_in),
    .hi_in  (hi_in)
  );

  iopm_eval #(.WORD_W(WORD_W), .WIN_W(WIN_W)) u_eval (
    .word    (word_q),
    .bit_sel (port_q[2:0]),
    .size    (size_q),
    .hit     (hit)
  );

  assign accept = req_valid && req_ready;

  // Next state and word load.
  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    word_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_CHECK_PRIV;
      end
      ST_CHECK_PRIV: begin
        if (bypass) begin
          state_d = ST_IDLE;
        end else if (lo_in) begin
          state_d = ST_READ;
        end else begin
          state_d = ST_EVAL;
          word_d  = '1;
          word_en = 1'b1;
        end
      end
      ST_READ: begin
        if (mem_rd_valid) begin
          state_d = ST_EVAL;
          word_d  = {hi_in ? mem_rd_data[WORD_W-1:BYTE_W] : {BYTE_W{1'b1}},
                     mem_rd_data[BYTE_W-1:0]};
          word_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      port_q  <= '0;
      size_q  <= '0;
      cpl_q   <= '0;
      iopl_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else if (accept) begin
      port_q  <= req_port;
      size_q  <= req_size;
      cpl_q   <= req_cpl;
      iopl_q  <= req_iopl;
      base_q  <= tss_map_base;
      limit_q <= tss_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    mem_rd_req  = (state_q == ST_READ);
    mem_rd_addr = off_lo[OFF_W-1:0];
    done        = ((state_q == ST_CHECK_PRIV) && bypass) || (state_q == ST_EVAL);
    fault       = (state_q == ST_EVAL) && hit;
    allow       = done && !fault;
  end

  // R1: a bypassing request is granted next cycle without a read.
  a_r1_bypass_grant: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && (req_cpl <= req_iopl)) |=> (done && allow && !mem_rd_req));

  // R6: first byte beyond the limit faults next cycle without a read.
  a_r6_out_of_limit: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((state_q == ST_CHECK_PRIV) && !bypass && !lo_in) |=> (done && fault && !mem_rd_req));

  // R7: the upper byte can be inside the limit only if the lower one is.
  a_r7_limit_order: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |-> (lo_in || !hi_in));

  // R8: one result per pulse, result flags only with done.
  a_r8_result_onehot: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> $onehot({allow, fault}));
  a_r8_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done |-> (!allow && !fault));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> (!done && req_ready));
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_rd_req |-> !req_ready);

  // R9: read request held with a stable address until data arrives.
  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

endmodule

// File: tb/iopm_checker_tb.sv
module iopm_checker_tb;
  localparam int CLK_P   = 10;
  localparam int MEM_N   = 1024;
  localparam int WD_LIM  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_port = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_cpl = '0;
  logic [1:0]  req_iopl = '0;
  logic [15:0] tss_map_base = '0;
  logic [15:0] tss_limit = '0;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic        done, allow, fault;

  logic [7:0]  mem [MEM_N];
  int          lat = 1;
  int          lat_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  iopm_checker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_size(req_size),
    .req_cpl(req_cpl), .req_iopl(req_iopl),
    .tss_map_base(tss_map_base), .tss_limit(tss_limit),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .allow(allow), .fault(fault)
  );

  // Bitmap memory with programmable latency.
  always @(posedge clk) begin
    if (mem_rd_valid) begin
      mem_rd_valid <= 1'b0;
      lat_cnt      <= 0;
    end else if (mem_rd_req) begin
      if (lat_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= {mem[(mem_rd_addr + 16'd1) % MEM_N], mem[mem_rd_addr % MEM_N]};
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIM) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIM);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent model: 1 means fault.
  function automatic logic model_fault(input logic [15:0] port, input logic [1:0] sz,
                                       input logic [15:0] base, input logic [15:0] lim);
    int nbits;
    logic f;
    nbits = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    f = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      int bi;
      logic [16:0] off;
      bi  = int'(port[2:0]) + i;
      off = {1'b0, base} + 17'(port >> 3) + 17'(bi / 8);
      if (off > {1'b0, lim}) f = 1'b1;
      else if (mem[off % MEM_N][bi % 8]) f = 1'b1;
    end
    return f;
  endfunction

  // One request; checks read address, hold, ready and result.
  task automatic run_req(input string tag, input logic [15:0] port, input logic [1:0] sz,
                         input logic [1:0] cpl, input logic [1:0] iopl,
                         input logic [15:0] base, input logic [15:0] lim);
    logic exp_fault, exp_read, saw_read, got;
    logic [15:0] addr0;
    logic [16:0] off;
    exp_fault = (cpl <= iopl) ? 1'b0 : model_fault(port, sz, base, lim);
    off       = {1'b0, base} + 17'(port >> 3);
    exp_read  = (cpl > iopl) && (off <= {1'b0, lim});
    saw_read  = 1'b0;
    got       = 1'b0;
    addr0     = '0;
    @(negedge clk);
    chk({tag, " R8 ready idle"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_port = port; req_size = sz; req_cpl = cpl; req_iopl = iopl;
    tss_map_base = base; tss_limit = lim;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (mem_rd_req) begin
        if (!saw_read) begin
          addr0 = mem_rd_addr;
          chk({tag, " R2 read addr"}, 32'(mem_rd_addr), 32'(off[15:0]));
        end else begin
          chk({tag, " R9 addr held"}, 32'(mem_rd_addr), 32'(addr0));
        end
        chk({tag, " R8 not ready busy"}, 32'(req_ready), 32'd0);
        saw_read = 1'b1;
      end
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk({tag, " R8 done seen"}, 32'(got), 32'd1);
    chk({tag, " R1/R6 read issued"}, 32'(saw_read), 32'(exp_read));
    chk({tag, " R5 fault"}, 32'(fault), 32'(exp_fault));
    chk({tag, " R5 allow"}, 32'(allow), 32'(!exp_fault));
    @(negedge clk);
    chk({tag, " R8 single pulse"}, 32'({done, allow, fault}), 32'd0);
  endtask

  task automatic t_reset();
    chk("R8 reset ready", 32'(req_ready), 32'd1);
    chk("R8 reset done", 32'({done, allow, fault}), 32'd0);
    chk("R9 reset no read", 32'(mem_rd_req), 32'd0);
  endtask

  task automatic t_bypass();
    mem[16'h100 + 5] = 8'hFF;
    run_req("R1 cpl0 iopl0", 16'd41, 2'b00, 2'd0, 2'd0, 16'h100, 16'h300);
    run_req("R1 cpl2 iopl3", 16'd41, 2'b10, 2'd2, 2'd3, 16'h100, 16'h300);
    run_req("R1 cpl3 iopl2 no bypass", 16'd41, 2'b00, 2'd3, 2'd2, 16'h100, 16'h300);
  endtask

  task automatic t_example();
    mem[16'h100 + 5] = 8'h02;
    run_req("R2 port41 set", 16'd41, 2'b00, 2'd3, 2'd0, 16'h100, 16'h300);
    run_req("R2 port40 clear", 16'd40, 2'b00, 2'd3, 2'd0, 16'h100, 16'h300);
    run_req("R2 port42 clear", 16'd42, 2'b00, 2'd3, 2'd0, 16'h100, 16'h300);
  endtask

  task automatic t_sizes();
    mem[16'h120] = 8'b0001_0000;
    mem[16'h121] = 8'h00;
    run_req("R3 size1 below", 16'd3, 2'b00, 2'd1, 2'd0, 16'h120, 16'h300);
    run_req("R3 size2 below", 16'd2, 2'b01, 2'd1, 2'd0, 16'h120, 16'h300);
    run_req("R3 size2 reach", 16'd3, 2'b01, 2'd1, 2'd0, 16'h120, 16'h300);
    run_req("R3 size4 reach", 16'd1, 2'b10, 2'd1, 2'd0, 16'h120, 16'h300);
    run_req("R3 size code11", 16'd1, 2'b11, 2'd1, 2'd0, 16'h120, 16'h300);
    run_req("R3 size4 above", 16'd5, 2'b10, 2'd1, 2'd0, 16'h120, 16'h300);
  endtask

  task automatic t_cross();
    mem[16'h140] = 8'h00;
    mem[16'h141] = 8'h01;
    run_req("R4 bit6 cross set", 16'd6, 2'b10, 2'd3, 2'd1, 16'h140, 16'h300);
    run_req("R4 bit7 size2 set", 16'd7, 2'b01, 2'd3, 2'd1, 16'h140, 16'h300);
    mem[16'h141] = 8'h08;
    run_req("R4 bit5 cross clear", 16'd5, 2'b10, 2'd3, 2'd1, 16'h140, 16'h300);
    run_req("R4 bit7 cross bit3", 16'd7, 2'b10, 2'd3, 2'd1, 16'h140, 16'h300);
  endtask

  task automatic t_limit();
    mem[16'h180] = 8'h00;
    mem[16'h181] = 8'h00;
    run_req("R6 beyond limit", 16'd16, 2'b00, 2'd3, 2'd0, 16'h180, 16'h181);
    run_req("R6 carry 17 bits", 16'd8, 2'b00, 2'd3, 2'd0, 16'hFFFF, 16'hFFFF);
    run_req("R6 at limit ok", 16'd8, 2'b00, 2'd3, 2'd0, 16'h180, 16'h181);
    mem[16'h182] = 8'h00;
    run_req("R7 upper out size2", 16'd15, 2'b01, 2'd3, 2'd0, 16'h180, 16'h181);
    run_req("R7 upper out size1", 16'd15, 2'b00, 2'd3, 2'd0, 16'h180, 16'h181);
    run_req("R7 upper out size4 low", 16'd8, 2'b10, 2'd3, 2'd0, 16'h180, 16'h181);
  endtask

  task automatic t_latency();
    mem[16'h1C0] = 8'h00;
    mem[16'h1C1] = 8'h00;
    lat = 0;
    run_req("R9 latency0", 16'd0, 2'b10, 2'd2, 2'd1, 16'h1C0, 16'h300);
    lat = 6;
    run_req("R9 latency6", 16'd0, 2'b10, 2'd2, 2'd1, 16'h1C0, 16'h300);
    mem[16'h1C0] = 8'h80;
    run_req("R9 latency6 fault", 16'd4, 2'b10, 2'd2, 2'd1, 16'h1C0, 16'h300);
    lat = 1;
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_example();
    t_sizes();
    t_cross();
    t_limit();
    t_latency();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule